// File: doc/BRIEF.md
# Peripheral-Paced DMA Channel

A single DMA channel that copies elements between memory and a peripheral data port, one element per beat, each beat a read from the source address followed by a write of the same word to the destination address. Software sets it up through a small register bus: a global register holding a master enable, and four channel registers for the control words and the two addresses. The peripheral paces the copy. A burst of 1, 4, 8 or 16 beats starts only when the chosen request line is high, and the channel returns a one-cycle acknowledge when that burst ends.

Either address can be held fixed (a peripheral data port) or can advance by the element width after every beat (a memory buffer). Software may pause the channel between beats and resume it later, or abort the transfer by clearing the channel enable. Normal completion and memory bus errors each leave a code in a stop-status field. A level interrupt reports that code when the matching enable bit is set, and software clears the code by writing zeros to it.

Top module: `dma_channel`

## Requirements
- R1: After reset every register reads as zero, `irq` is low and `mem_req` is low.
- R2: Register 0x00 bit 31 is the master enable. While it is clear, `mem_req` stays low even when the channel is enabled and its request line is high. Setting it lets a pending transfer run.
- R3: Control word A (offset 0x10) has bit 31 = channel enable, bit 30 = pause, bits [28:24] = request line select, bits [23:20] = burst code and bits [15:0] = burst count minus one. A burst starts only while `per_req[select]` is high, and `per_ack` pulses for one cycle at the end of each burst.
- R4: Burst code 0xF gives 16 beats, 0xD gives 8 and 0xB gives 4. Every other code gives 1 beat. A transfer moves (bits[15:0]+1) bursts.
- R5: Control word B (offset 0x14) has bits [27:26] = width code (0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes), bit 25 = hold source fixed and bit 24 = hold destination fixed. `mem_size` carries the width code. An address that is not held advances by the element width after each beat.
- R6: Each beat first reads from the current source address (`mem_we`=0) and then writes the word it read to the current destination address (`mem_we`=1).
- R7: The source register (0x18) and destination register (0x1C) read back the current addresses, during the transfer and after it.
- R8: While the pause bit is set, no new beat starts. When it is cleared, the transfer continues from where it stopped and moves the full count.
- R9: Clearing the channel enable during a transfer stops all memory requests and leaves the stop-status field unchanged.
- R10: When the last beat of the last burst is written, stop status (control B bits [18:16]) becomes 3'b101 and the channel enable bit clears.
- R11: A memory response with `mem_err` high ends the transfer. Stop status becomes 3'b010, the channel enable clears and neither address advances for that beat.
- R12: `irq` is high exactly while (stop status is 3'b101 and control B bit 19 is set) or (stop status is 3'b010 and control B bit 20 is set). Writing control B clears each stop-status bit written as 0 and keeps each bit written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Write when high together with reg_sel |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| per_req | input | 32 | Peripheral request lines |
| per_ack | output | 1 | One-cycle pulse at the end of each burst |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Element width code |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ready | input | 1 | Memory accepts or completes the request this cycle |
| mem_err | input | 1 | Memory response is an error (valid with mem_ready) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are a channel frozen mid-transfer and a transfer cut short by a bus error on a write beat. To freeze the channel, the bench lets a long single-beat transfer run until its memory model has counted five writes, sets the pause bit, and then shows that the write count and the source address readback both stay still over a long window before it resumes. For the bus error, the memory model has an arming flag that turns the first write into an error response, so the bench can check that the stop code is set and that the addresses stay where they were. A table of burst, width and fixed-address mixes drives the ordinary transfers, and a model that follows each beat checks every address and data word.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARM,
    SQ_RD,
    SQ_WR,
    SQ_GAP
  } seq_state_e;

  localparam logic [2:0] STOP_NONE = 3'b000;
  localparam logic [2:0] STOP_ERR  = 3'b010;
  localparam logic [2:0] STOP_DONE = 3'b101;

  localparam logic [7:0] OFS_GLOBAL = 8'h00;
  localparam logic [7:0] OFS_CTRL_A = 8'h10;
  localparam logic [7:0] OFS_CTRL_B = 8'h14;
  localparam logic [7:0] OFS_SRC    = 8'h18;
  localparam logic [7:0] OFS_DST    = 8'h1C;

  localparam logic [31:0] GLOBAL_MASK  = 32'h8000_0000;
  localparam logic [31:0] CTRL_A_MASK  = 32'hDFF0_FFFF;
  localparam logic [31:0] CTRL_B_RW    = 32'h0F18_0000;
  localparam logic [31:0] CTRL_B_STOP  = 32'h0007_0000;

  localparam int REQ_LINES = 32;

  // Beats carried by one burst for a given burst code.
  function automatic logic [4:0] beats_of(input logic [3:0] code);
    case (code)
      4'hF:    beats_of = 5'd16;
      4'hD:    beats_of = 5'd8;
      4'hB:    beats_of = 5'd4;
      default: beats_of = 5'd1;
    endcase
  endfunction

  // Bus size code; the unused code 3 is treated as a word.
  function automatic logic [1:0] size_of(input logic [1:0] wcode);
    size_of = (wcode == 2'd3) ? 2'd2 : wcode;
  endfunction

  // Address step after a beat: zero when held, else element bytes.
  function automatic logic [2:0] step_of(input logic [1:0] wcode, input logic held);
    logic [2:0] bytes;
    case (wcode)
      2'd0:    bytes = 3'd1;
      2'd1:    bytes = 3'd2;
      default: bytes = 3'd4;
    endcase
    step_of = held ? 3'd0 : bytes;
  endfunction

endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              beat_adv,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic              glob_en,
  output logic              ch_en,
  output logic              ch_pause,
  output logic [4:0]        req_sel,
  output logic [3:0]        burst_code,
  output logic [15:0]       burst_last,
  output logic [1:0]        width_code,
  output logic              fix_src,
  output logic              fix_dst,
  output logic              err_ie,
  output logic              done_ie,
  output logic [2:0]        stop_code,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);

  logic [31:0]       glob_q;
  logic [31:0]       ctrl_a_q;
  logic [31:0]       ctrl_b_q;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;
  logic              wr_hit;

  assign wr_hit = reg_sel & reg_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_q   <= '0;
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
      src_q    <= '0;
      dst_q    <= '0;
    end else begin
      if (wr_hit) begin
        case (reg_addr)
          REG_AW'(OFS_GLOBAL): glob_q   <= reg_wdata & GLOBAL_MASK;
          REG_AW'(OFS_CTRL_A): ctrl_a_q <= reg_wdata & CTRL_A_MASK;
          REG_AW'(OFS_CTRL_B): ctrl_b_q <= (reg_wdata & CTRL_B_RW) |
                                           (ctrl_b_q & reg_wdata & CTRL_B_STOP);
          REG_AW'(OFS_SRC):    src_q    <= reg_wdata[ADDR_W-1:0];
          REG_AW'(OFS_DST):    dst_q    <= reg_wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
      // Engine events take priority over a software write in the same cycle.
      if (beat_adv) begin
        src_q <= src_q + ADDR_W'(step_of(ctrl_b_q[27:26], ctrl_b_q[25]));
        dst_q <= dst_q + ADDR_W'(step_of(ctrl_b_q[27:26], ctrl_b_q[24]));
      end
      if (xfer_done) begin
        ctrl_a_q[31]    <= 1'b0;
        ctrl_b_q[18:16] <= STOP_DONE;
      end
      if (xfer_err) begin
        ctrl_a_q[31]    <= 1'b0;
        ctrl_b_q[18:16] <= STOP_ERR;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(OFS_GLOBAL): reg_rdata = glob_q;
      REG_AW'(OFS_CTRL_A): reg_rdata = ctrl_a_q;
      REG_AW'(OFS_CTRL_B): reg_rdata = ctrl_b_q;
      REG_AW'(OFS_SRC):    reg_rdata = 32'(src_q);
      REG_AW'(OFS_DST):    reg_rdata = 32'(dst_q);
      default:             reg_rdata = '0;
    endcase
  end

  assign glob_en    = glob_q[31];
  assign ch_en      = ctrl_a_q[31];
  assign ch_pause   = ctrl_a_q[30];
  assign req_sel    = ctrl_a_q[28:24];
  assign burst_code = ctrl_a_q[23:20];
  assign burst_last = ctrl_a_q[15:0];
  assign width_code = ctrl_b_q[27:26];
  assign fix_src    = ctrl_b_q[25];
  assign fix_dst    = ctrl_b_q[24];
  assign err_ie     = ctrl_b_q[20];
  assign done_ie    = ctrl_b_q[19];
  assign stop_code  = ctrl_b_q[18:16];
  assign src_addr   = src_q;
  assign dst_addr   = dst_q;

endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq
  import dma_ch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glob_en,
  input  logic              ch_en,
  input  logic              ch_pause,
  input  logic              req_hit,
  input  logic [3:0]        burst_code,
  input  logic [15:0]       burst_last,
  input  logic [1:0]        width_code,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  output logic              per_ack,
  output logic              beat_adv,
  output logic              xfer_done,
  output logic              xfer_err
);

  seq_state_e        state_q;
  logic [4:0]        beat_q;
  logic [15:0]       burst_q;
  logic [DATA_W-1:0] data_q;
  logic [4:0]        beats;
  logic              run;
  logic              beat_ok;
  logic              bus_fail;
  logic              last_beat;
  logic              last_burst;

  assign beats      = beats_of(burst_code);
  assign run        = glob_en & ch_en & ~ch_pause;
  assign last_beat  = (beat_q == beats - 5'd1);
  assign last_burst = (burst_q == burst_last);

  assign mem_req   = ((state_q == SQ_RD) || (state_q == SQ_WR)) && glob_en && ch_en;
  assign mem_we    = (state_q == SQ_WR);
  assign mem_size  = size_of(width_code);
  assign mem_addr  = (state_q == SQ_WR) ? dst_addr : src_addr;
  assign mem_wdata = data_q;

  assign beat_ok  = mem_req & mem_ready & ~mem_err;
  assign bus_fail = mem_req & mem_ready & mem_err;

  assign beat_adv  = beat_ok & (state_q == SQ_WR);
  assign per_ack   = beat_adv & last_beat;
  assign xfer_done = per_ack & last_burst;
  assign xfer_err  = bus_fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      beat_q  <= '0;
      burst_q <= '0;
      data_q  <= '0;
    end else if (!ch_en && state_q != SQ_IDLE) begin
      state_q <= SQ_IDLE;
    end else begin
      case (state_q)
        SQ_IDLE: if (ch_en && glob_en) begin
          burst_q <= '0;
          state_q <= SQ_ARM;
        end
        SQ_ARM: if (run && req_hit) begin
          beat_q  <= '0;
          state_q <= SQ_RD;
        end
        SQ_RD: begin
          if (bus_fail) begin
            state_q <= SQ_IDLE;
          end else if (beat_ok) begin
            data_q  <= mem_rdata;
            state_q <= SQ_WR;
          end
        end
        SQ_WR: begin
          if (bus_fail) begin
            state_q <= SQ_IDLE;
          end else if (beat_ok) begin
            if (!last_beat) begin
              beat_q  <= beat_q + 5'd1;
              state_q <= SQ_GAP;
            end else if (last_burst) begin
              state_q <= SQ_IDLE;
            end else begin
              burst_q <= burst_q + 16'd1;
              state_q <= SQ_ARM;
            end
          end
        end
        SQ_GAP: if (run) state_q <= SQ_RD;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_ch_irq.sv
module dma_ch_irq
  import dma_ch_pkg::*;
(
  input  logic [2:0] stop_code,
  input  logic       done_ie,
  input  logic       err_ie,
  output logic       irq
);

  assign irq = ((stop_code == STOP_DONE) && done_ie) ||
               ((stop_code == STOP_ERR)  && err_ie);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_ch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [REQ_LINES-1:0] per_req,
  output logic                 per_ack,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [1:0]           mem_size,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 mem_ready,
  input  logic                 mem_err,
  output logic                 irq
);

  logic              glob_en, ch_en, ch_pause;
  logic [4:0]        req_sel;
  logic [3:0]        burst_code;
  logic [15:0]       burst_last;
  logic [1:0]        width_code;
  logic              fix_src, fix_dst, err_ie, done_ie;
  logic [2:0]        stop_code;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic              beat_adv, xfer_done, xfer_err;
  logic              req_hit;

  assign req_hit = per_req[req_sel];

  dma_ch_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .beat_adv   (beat_adv),
    .xfer_done  (xfer_done),
    .xfer_err   (xfer_err),
    .glob_en    (glob_en),
    .ch_en      (ch_en),
    .ch_pause   (ch_pause),
    .req_sel    (req_sel),
    .burst_code (burst_code),
    .burst_last (burst_last),
    .width_code (width_code),
    .fix_src    (fix_src),
    .fix_dst    (fix_dst),
    .err_ie     (err_ie),
    .done_ie    (done_ie),
    .stop_code  (stop_code),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr)
  );

  dma_ch_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_en    (glob_en),
    .ch_en      (ch_en),
    .ch_pause   (ch_pause),
    .req_hit    (req_hit),
    .burst_code (burst_code),
    .burst_last (burst_last),
    .width_code (width_code),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_size   (mem_size),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ready  (mem_ready),
    .mem_err    (mem_err),
    .per_ack    (per_ack),
    .beat_adv   (beat_adv),
    .xfer_done  (xfer_done),
    .xfer_err   (xfer_err)
  );

  dma_ch_irq u_irq (
    .stop_code (stop_code),
    .done_ie   (done_ie),
    .err_ie    (err_ie),
    .irq       (irq)
  );

endmodule

// File: rtl/dma_ch_chk.sv
module dma_ch_chk
  import dma_ch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              glob_en,
  input logic              ch_en,
  input logic              ch_pause,
  input logic              per_ack,
  input logic              beat_adv,
  input logic              fix_src,
  input logic              fix_dst,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              xfer_done,
  input logic              xfer_err,
  input logic [2:0]        stop_code,
  input logic              irq
);

  // R2
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> glob_en);

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);

  // R5
  fixed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv && fix_src |=> $stable(src_addr));

  // R5
  fixed_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv && fix_dst |=> $stable(dst_addr));

  // R8
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_pause && !mem_req |=> !mem_req);

  // R9
  abort_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !mem_req);

  // R10
  done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !ch_en && stop_code == STOP_DONE);

  // R11
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !ch_en && stop_code == STOP_ERR);

  // R12
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stop_code != STOP_NONE);

endmodule

bind dma_channel dma_ch_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .glob_en   (glob_en),
  .ch_en     (ch_en),
  .ch_pause  (ch_pause),
  .per_ack   (per_ack),
  .beat_adv  (beat_adv),
  .fix_src   (fix_src),
  .fix_dst   (fix_dst),
  .src_addr  (src_addr),
  .dst_addr  (dst_addr),
  .xfer_done (xfer_done),
  .xfer_err  (xfer_err),
  .stop_code (stop_code),
  .irq       (irq)
);

// File: tb/test_dma_channel.sv
`timescale 1ns/1ps
module test_dma_channel;
  import dma_ch_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] per_req = '0;
  logic        per_ack, mem_req, mem_we, irq;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready, mem_err;
  logic        err_arm = 1'b0;

  always #2.5 clk = ~clk;

  dma_channel i_dma_channel (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .per_req(per_req), .per_ack(per_ack), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    pat = {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  function automatic int t_beats(input logic [3:0] bt);
    if (bt == 4'hF) return 16;
    if (bt == 4'hD) return 8;
    if (bt == 4'hB) return 4;
    return 1;
  endfunction

  function automatic int t_bytes(input logic [1:0] tw);
    return 1 << tw;
  endfunction

  function automatic logic [31:0] mk_a(input logic en, input logic ps, input logic [4:0] sel,
                                       input logic [3:0] bt, input logic [15:0] tc);
    mk_a = {en, ps, 1'b0, sel, bt, 4'h0, tc};
  endfunction

  function automatic logic [31:0] mk_b(input logic [1:0] tw, input logic fs, input logic fd,
                                       input logic ei, input logic ci, input logic [2:0] st);
    mk_b = {4'h0, tw, fs, fd, 3'b000, ei, ci, st, 16'h0000};
  endfunction

  assign mem_rdata = pat(mem_addr);
  assign mem_ready = 1'b1;
  assign mem_err   = err_arm & mem_req & mem_we;

  // Beat-level memory model
  int          n_rd = 0, n_wr = 0, n_ack = 0, n_bad = 0;
  logic [31:0] exp_src = '0, exp_dst = '0, sstep = '0, dstep = '0;
  logic [1:0]  exp_size = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ready && !mem_err) begin
        if (mem_size != exp_size) n_bad++;
        if (mem_we) begin
          n_wr++;
          if (mem_addr != exp_dst || mem_wdata != pat(exp_src)) n_bad++;
          exp_src = exp_src + sstep;
          exp_dst = exp_dst + dstep;
        end else begin
          n_rd++;
          if (mem_addr != exp_src) n_bad++;
        end
      end
      if (per_ack) n_ack++;
    end
  end

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic clr_mon();
    n_rd = 0; n_wr = 0; n_ack = 0; n_bad = 0;
  endtask

  task automatic setup(input logic [1:0] tw, input logic fs, input logic fd,
                       input logic ei, input logic ci);
    reg_write(OFS_SRC, 32'h100);
    reg_write(OFS_DST, 32'h200);
    exp_src = 32'h100; exp_dst = 32'h200;
    sstep = fs ? 0 : t_bytes(tw);
    dstep = fd ? 0 : t_bytes(tw);
    exp_size = tw;
    clr_mon();
    reg_write(OFS_CTRL_B, mk_b(tw, fs, fd, ei, ci, 3'b000));
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    bit ok;
    ok = 0;
    for (int k = 0; k < 4000; k++) begin
      reg_read(OFS_CTRL_A, v);
      if (!v[31]) begin ok = 1; break; end
    end
    if (!ok) check({tag, " timeout"}, 32'd0, 32'd1);
  endtask

  task automatic wait_writes(input int n);
    for (int k = 0; k < 4000; k++) begin
      if (n_wr >= n) break;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [3:0]  bt;
    logic [15:0] tc;
    logic [1:0]  tw;
    logic        fs;
    logic        fd;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{bt: 4'h0, tc: 16'd3, tw: 2'd2, fs: 1'b0, fd: 1'b1},
    '{bt: 4'hB, tc: 16'd1, tw: 2'd1, fs: 1'b0, fd: 1'b0},
    '{bt: 4'hD, tc: 16'd0, tw: 2'd0, fs: 1'b1, fd: 1'b0},
    '{bt: 4'hF, tc: 16'd1, tw: 2'd2, fs: 1'b0, fd: 1'b0},
    '{bt: 4'h3, tc: 16'd2, tw: 2'd0, fs: 1'b0, fd: 1'b0},
    '{bt: 4'hB, tc: 16'd2, tw: 2'd1, fs: 1'b1, fd: 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s0;
    int w0, t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    reg_read(OFS_GLOBAL, v);  check("R1 global", v, 0);
    reg_read(OFS_CTRL_A, v);  check("R1 ctrl_a", v, 0);
    reg_read(OFS_CTRL_B, v);  check("R1 ctrl_b", v, 0);
    reg_read(OFS_SRC, v);     check("R1 src", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 mem_req", {31'd0, mem_req}, 0);

    // R2: master enable gates all traffic
    setup(2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
    per_req = 32'h1 << 4;
    reg_write(OFS_CTRL_A, mk_a(1'b1, 1'b0, 5'd4, 4'h0, 16'd0));
    repeat (40) @(negedge clk);
    check("R2 no reads while master off", n_rd, 0);
    reg_read(OFS_SRC, v); check("R2 src unchanged", v, 32'h100);
    reg_write(OFS_GLOBAL, 32'h8000_0000);
    wait_idle("R2");
    check("R2 runs after master on", n_wr, 1);
    reg_write(OFS_CTRL_B, mk_b(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000));

    // R3: request line gating
    setup(2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
    per_req = 32'h0;
    reg_write(OFS_CTRL_A, mk_a(1'b1, 1'b0, 5'd9, 4'h0, 16'd2));
    repeat (30) @(negedge clk);
    check("R3 idle without request", n_rd, 0);
    per_req = 32'h1 << 10;
    repeat (30) @(negedge clk);
    check("R3 idle on other line", n_rd, 0);
    per_req = 32'h1 << 9;
    wait_idle("R3");
    check("R3 acks", n_ack, 3);
    reg_write(OFS_CTRL_B, mk_b(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000));

    // Table of burst/width/fixed mixes: R4 R5 R6 R7 R10 R12
    for (int i = 0; i < 6; i++) begin
      vec_t c;
      int total, bursts;
      c = VECS[i];
      bursts = int'(c.tc) + 1;
      total = t_beats(c.bt) * bursts;
      setup(c.tw, c.fs, c.fd, 1'b1, 1'b1);
      per_req = 32'h1 << (i + 2);
      reg_write(OFS_CTRL_A, mk_a(1'b1, 1'b0, 5'(i + 2), c.bt, c.tc));
      wait_idle("R4 table");
      check($sformatf("R4 beats vec%0d", i), n_wr, total);
      check($sformatf("R3 acks vec%0d", i), n_ack, bursts);
      check($sformatf("R6 addr/data/size vec%0d", i), n_bad, 0);
      reg_read(OFS_SRC, v);
      check($sformatf("R7 src vec%0d", i), v, 32'h100 + (c.fs ? 0 : total * t_bytes(c.tw)));
      reg_read(OFS_DST, v);
      check($sformatf("R5 dst vec%0d", i), v, 32'h200 + (c.fd ? 0 : total * t_bytes(c.tw)));
      reg_read(OFS_CTRL_B, v);
      check($sformatf("R10 stop vec%0d", i), {29'd0, v[18:16]}, 32'd5);
      check($sformatf("R12 irq on vec%0d", i), {31'd0, irq}, 1);
      reg_write(OFS_CTRL_B, mk_b(c.tw, c.fs, c.fd, 1'b1, 1'b1, 3'b000));
      check($sformatf("R12 irq cleared vec%0d", i), {31'd0, irq}, 0);
    end

    // R8: pause freezes, resume completes
    setup(2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
    per_req = 32'h1 << 1;
    reg_write(OFS_CTRL_A, mk_a(1'b1, 1'b0, 5'd1, 4'h0, 16'd39));
    wait_writes(5);
    reg_write(OFS_CTRL_A, mk_a(1'b1, 1'b1, 5'd1, 4'h0, 16'd39));
    repeat (3) @(negedge clk);
    w0 = n_wr;
    reg_read(OFS_SRC, s0);
    repeat (40) @(negedge clk);
    check("R8 no writes while paused", n_wr, w0);
    reg_read(OFS_SRC, v); check("R8 src frozen", v, s0);
    reg_write(OFS_CTRL_A, mk_a(1'b1, 1'b0, 5'd1, 4'h0, 16'd39));
    wait_idle("R8");
    check("R8 full count after resume", n_wr, 40);
    reg_read(OFS_SRC, v); check("R8 src final", v, 32'h100 + 160);
    check("R8 data", n_bad, 0);
    reg_write(OFS_CTRL_B, mk_b(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000));

    // R9: abort by clearing enable
    setup(2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
    reg_write(OFS_CTRL_A, mk_a(1'b1, 1'b0, 5'd1, 4'h0, 16'd199));
    wait_writes(5);
    reg_write(OFS_CTRL_A, mk_a(1'b0, 1'b0, 5'd1, 4'h0, 16'd199));
    repeat (2) @(negedge clk);
    t0 = n_rd + n_wr;
    repeat (40) @(negedge clk);
    check("R9 traffic stopped", n_rd + n_wr, t0);
    reg_read(OFS_CTRL_B, v); check("R9 stop unchanged", {29'd0, v[18:16]}, 0);
    check("R9 irq low", {31'd0, irq}, 0);

    // R11: bus error on a write beat
    setup(2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    err_arm = 1'b1;
    reg_write(OFS_CTRL_A, mk_a(1'b1, 1'b0, 5'd1, 4'h0, 16'd3));
    wait_idle("R11");
    err_arm = 1'b0;
    reg_read(OFS_CTRL_B, v); check("R11 stop err", {29'd0, v[18:16]}, 32'd2);
    reg_read(OFS_SRC, v); check("R11 src held", v, 32'h100);
    reg_read(OFS_DST, v); check("R11 dst held", v, 32'h200);
    check("R11 no good writes", n_wr, 0);
    check("R12 irq on error", {31'd0, irq}, 1);
    reg_write(OFS_CTRL_B, mk_b(2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111));
    reg_read(OFS_CTRL_B, v); check("R12 ones keep stop", {29'd0, v[18:16]}, 32'd2);
    reg_write(OFS_CTRL_B, mk_b(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111));
    check("R12 irq off when err enable clear", {31'd0, irq}, 0);
    reg_write(OFS_CTRL_B, mk_b(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000));

    // R12: completion with completion interrupt disabled
    setup(2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    reg_write(OFS_CTRL_A, mk_a(1'b1, 1'b0, 5'd1, 4'h0, 16'd0));
    wait_idle("R12");
    reg_read(OFS_CTRL_B, v); check("R10 stop done", {29'd0, v[18:16]}, 32'd5);
    check("R12 irq masked", {31'd0, irq}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule